// File: doc/BRIEF.md
# Load/Store Address Unit

This block turns a memory instruction's base register and immediate offset into the byte address of the access. It also produces the updated base value for the register file and the beats that go out on a 64-bit memory port. The offset comes either as a short 5-bit constant or as a long 15-bit constant. It is scaled by the access size, which can be one, two, four or eight bytes, and it can be added to or subtracted from the base. The result is either used directly or confined to a power-of-two circular block that is selected per request.

Aligned requests must start on a multiple of their own size; a request that does not raises an error pulse and is dropped. Non-aligned requests may start on any byte. When such a request runs past the end of an 8-byte memory word, the unit issues two consecutive beats with byte enables. For stores, the data is rotated onto the right byte lanes. For loads, the two returned words are merged and shifted down so that the first byte of the access lands in bits 7:0. A load result carries a side tag chosen by the request, so an address formed from one register file can deliver data into the other.

Top module: `lsu_agen`

## Requirements
- R1: The effective offset is the selected constant times the access size in bytes. Size codes are 0=1, 1=2, 2=4 and 3=8 bytes. With `req_long_ofs`=1 the constant is all 15 bits of `req_offset`, otherwise only bits 4:0. In non-aligned mode only bits 4:0 are used, whatever `req_long_ofs` says.
- R2: With `req_neg`=1 the effective offset is subtracted from the base. Otherwise it is added. All arithmetic is modulo 2^32.
- R3: `req_mode` selects the address and the update. Mode 0 accesses at base+offset with no update. Mode 1 accesses at base+offset and writes that value back. Mode 2 accesses at base and writes back base+offset. Mode 3 behaves as mode 0. `wb_valid`/`wb_addr` appear in the cycle after acceptance.
- R4: With `req_circ`=1 and N=`req_circ_n`, address bits above bit N come from the base and bits N:0 come from the sum. This applies to both the access address and the write-back value. It gives a block of 2^(N+1) bytes.
- R5: In aligned mode (`req_unaligned`=0), an access address that is not a multiple of the size pulses `err_misalign` in the cycle after acceptance. It produces no memory beat and no write-back.
- R6: The first beat appears in the cycle after acceptance. `mem_addr` has bits 2:0 zero. Lane k of `mem_be`/`mem_wdata` is byte address `mem_addr`+k. Across all beats, exactly the bytes from the access address up to address+size-1 are enabled.
- R7: When (address mod 8)+size exceeds 8, a second beat follows in the very next cycle at `mem_addr`+8 and carries the remaining bytes. Otherwise there is a single beat.
- R8: For a store, byte i of `req_wdata` is placed on the lane whose byte address is access address + i.
- R9: For a load, `rd_valid` pulses in the cycle after the last beat. `rd_data` holds the bytes read from address, address+1, … in ascending byte order, and the bits above the access size are zero. `mem_rdata` is sampled in each beat's own cycle.
- R10: `req_ready` is low exactly in the cycle where the first beat of a two-beat access is on the port. A request presented then is not taken, and it is accepted at the next edge.
- R11: `rd_side` equals the `req_side` of the load that produced `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this edge when high |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code (0..3 = 1,2,4,8 bytes) |
| req_mode | input | 2 | Update mode (0 none, 1 pre, 2 post, 3 none) |
| req_unaligned | input | 1 | Non-aligned access allowed |
| req_long_ofs | input | 1 | Use 15-bit offset instead of 5-bit |
| req_neg | input | 1 | Subtract offset |
| req_offset | input | 15 | Offset constant |
| req_base | input | 32 | Base register value |
| req_circ | input | 1 | Circular addressing |
| req_circ_n | input | 5 | Circular block exponent N (2^(N+1) bytes) |
| req_wdata | input | 64 | Store data, access byte 0 in bits 7:0 |
| req_side | input | 1 | Destination register file of a load |
| wb_valid | output | 1 | Base update valid |
| wb_addr | output | 32 | Updated base value |
| err_misalign | output | 1 | Aligned-mode misalignment pulse |
| mem_valid | output | 1 | Memory beat valid |
| mem_store | output | 1 | Beat is a write |
| mem_beat | output | 1 | 0 = first beat, 1 = second beat |
| mem_addr | output | 32 | 8-byte aligned beat address |
| mem_be | output | 8 | Byte enables per lane |
| mem_wdata | output | 64 | Lane-aligned store data |
| mem_rdata | input | 64 | Read data for the current beat |
| rd_valid | output | 1 | Load result valid |
| rd_data | output | 64 | Merged, right-justified load data |
| rd_side | output | 1 | Destination register file tag |

## Verification
The second beat of a boundary-crossing access and a newly presented request can meet in the same cycle. The same happens with the merged result of one load and the first beat of the next request. The bench holds a second request valid right behind a crossing non-aligned load. It checks that the port is busy for exactly one cycle. In the following cycle it checks that the first load's merged data and the new request's first beat appear together, each with the value that byte-level address arithmetic predicts.

// File: rtl/lsu_agen_pkg.sv
package lsu_agen_pkg;

  localparam int unsigned LANES = 8;

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_D = 2'd3} acc_size_e;
  typedef enum logic [1:0] {UM_NONE = 2'd0, UM_PRE = 2'd1, UM_POST = 2'd2, UM_RSV = 2'd3} upd_mode_e;

  // bytes moved by one access of the given size code
  function automatic logic [3:0] size_bytes(input logic [1:0] sz);
    return 4'd1 << sz;
  endfunction

  // byte-enable span over two consecutive 8-byte words
  function automatic logic [15:0] lane_span(input logic [2:0] lo, input logic [1:0] sz);
    logic [15:0] m;
    m = 16'h00FF >> (4'd8 - size_bytes(sz));
    return m << lo;
  endfunction

  function automatic logic crosses_word(input logic [2:0] lo, input logic [1:0] sz);
    logic [3:0] endp;
    endp = {1'b0, lo} + size_bytes(sz);
    return endp > 4'd8;
  endfunction

  function automatic logic misaligned(input logic [2:0] lo, input logic [1:0] sz);
    logic [2:0] m;
    m = 3'(size_bytes(sz) - 4'd1);
    return |(lo & m);
  endfunction

  // low N+1 bits set
  function automatic logic [63:0] circ_mask(input logic [5:0] n);
    return (64'd2 << n) - 64'd1;
  endfunction

  // keeps the bytes that belong to an access of the given size
  function automatic logic [63:0] keep_mask(input logic [1:0] sz);
    return {64{1'b1}} >> {(4'd8 - size_bytes(sz)), 3'b000};
  endfunction

endpackage

// File: rtl/lsu_ea_calc.sv
module lsu_ea_calc
  import lsu_agen_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned OFS_LONG = 15,
  parameter int unsigned OFS_SHRT = 5,
  parameter int unsigned CNW      = 5
) (
  input  logic [AW-1:0]       base,
  input  logic [OFS_LONG-1:0] offset,
  input  logic                use_long,
  input  logic                unaligned,
  input  logic                neg,
  input  logic [1:0]          size,
  input  logic [1:0]          mode,
  input  logic                circ,
  input  logic [CNW-1:0]      circ_n,
  output logic [AW-1:0]       ea,
  output logic [AW-1:0]       wb_addr,
  output logic                wb_en,
  output logic                misalign
);

  logic [OFS_LONG-1:0] ofs_sel;
  logic [AW-1:0]       scaled;
  logic [AW-1:0]       sum;
  logic [AW-1:0]       mask;
  logic [AW-1:0]       wrapped;

  always_comb begin
    ofs_sel = (use_long && !unaligned) ? offset : OFS_LONG'(offset[OFS_SHRT-1:0]);
    scaled  = AW'(ofs_sel) << size;
    sum     = neg ? (base - scaled) : (base + scaled);
    mask    = AW'(circ_mask(6'(circ_n)));
    wrapped = circ ? ((base & ~mask) | (sum & mask)) : sum;
    ea      = (upd_mode_e'(mode) == UM_POST) ? base : wrapped;
    wb_addr = wrapped;
    wb_en   = (upd_mode_e'(mode) == UM_PRE) || (upd_mode_e'(mode) == UM_POST);
    misalign = !unaligned && misaligned(ea[2:0], size);
  end

endmodule

// File: rtl/lsu_beat_seq.sv
module lsu_beat_seq
  import lsu_agen_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] ea,
  input  logic [1:0]    size,
  input  logic          store,
  input  logic [DW-1:0] wdata,
  input  logic          side,
  output logic          mem_valid,
  output logic          mem_store,
  output logic          mem_beat,
  output logic          mem_last,
  output logic [AW-1:0] mem_addr,
  output logic [DW/8-1:0] mem_be,
  output logic [DW-1:0] mem_wdata,
  output logic [2:0]    cur_lo,
  output logic [1:0]    cur_size,
  output logic          cur_side,
  output logic          hold
);

  localparam int unsigned NBYTE = DW / 8;

  logic            v_q, beat_q, split_q, store_q, side_q;
  logic [AW-1:0]   addr_q;
  logic [2:0]      lo_q;
  logic [1:0]      size_q;
  logic [2*NBYTE-1:0] be_q;
  logic [2*DW-1:0] wd_q;

  always_comb begin
    mem_valid = v_q;
    mem_store = store_q;
    mem_beat  = beat_q;
    mem_last  = !split_q || beat_q;
    mem_addr  = beat_q ? (addr_q + AW'(NBYTE)) : addr_q;
    mem_be    = v_q ? (beat_q ? be_q[2*NBYTE-1:NBYTE] : be_q[NBYTE-1:0]) : '0;
    mem_wdata = beat_q ? wd_q[2*DW-1:DW] : wd_q[DW-1:0];
    cur_lo    = lo_q;
    cur_size  = size_q;
    cur_side  = side_q;
    hold      = v_q && !split_q ? 1'b0 : (v_q && !beat_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q     <= 1'b0;
      beat_q  <= 1'b0;
      split_q <= 1'b0;
      store_q <= 1'b0;
      side_q  <= 1'b0;
      addr_q  <= '0;
      lo_q    <= '0;
      size_q  <= '0;
      be_q    <= '0;
      wd_q    <= '0;
    end else if (hold) begin
      beat_q <= 1'b1;
    end else if (start) begin
      v_q     <= 1'b1;
      beat_q  <= 1'b0;
      split_q <= crosses_word(ea[2:0], size);
      store_q <= store;
      side_q  <= side;
      addr_q  <= {ea[AW-1:3], 3'b000};
      lo_q    <= ea[2:0];
      size_q  <= size;
      be_q    <= lane_span(ea[2:0], size);
      wd_q    <= {{DW{1'b0}}, wdata} << {ea[2:0], 3'b000};
    end else begin
      v_q    <= 1'b0;
      beat_q <= 1'b0;
    end
  end

endmodule

// File: rtl/lsu_load_merge.sv
module lsu_load_merge
  import lsu_agen_pkg::*;
#(
  parameter int unsigned DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mem_valid,
  input  logic          mem_store,
  input  logic          mem_beat,
  input  logic          mem_last,
  input  logic [2:0]    lo,
  input  logic [1:0]    size,
  input  logic          side,
  input  logic [DW-1:0] rdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          rd_side
);

  logic [DW-1:0]   first_q;
  logic [2*DW-1:0] joined;
  logic [DW-1:0]   merged;
  logic            take;

  always_comb begin
    take   = mem_valid && !mem_store;
    joined = {(mem_beat ? rdata : {DW{1'b0}}), (mem_beat ? first_q : rdata)};
    joined = joined >> {lo, 3'b000};
    merged = joined[DW-1:0] & DW'(keep_mask(size));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_side  <= 1'b0;
    end else begin
      rd_valid <= take && mem_last;
      if (take && !mem_beat) first_q <= rdata;
      if (take && mem_last) begin
        rd_data <= merged;
        rd_side <= side;
      end
    end
  end

endmodule

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_agen_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned DW       = 64,
  parameter int unsigned OFS_LONG = 15,
  parameter int unsigned OFS_SHRT = 5,
  parameter int unsigned CNW      = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_store,
  input  logic [1:0]          req_size,
  input  logic [1:0]          req_mode,
  input  logic                req_unaligned,
  input  logic                req_long_ofs,
  input  logic                req_neg,
  input  logic [OFS_LONG-1:0] req_offset,
  input  logic [AW-1:0]       req_base,
  input  logic                req_circ,
  input  logic [CNW-1:0]      req_circ_n,
  input  logic [DW-1:0]       req_wdata,
  input  logic                req_side,
  output logic                wb_valid,
  output logic [AW-1:0]       wb_addr,
  output logic                err_misalign,
  output logic                mem_valid,
  output logic                mem_store,
  output logic                mem_beat,
  output logic [AW-1:0]       mem_addr,
  output logic [DW/8-1:0]     mem_be,
  output logic [DW-1:0]       mem_wdata,
  input  logic [DW-1:0]       mem_rdata,
  output logic                rd_valid,
  output logic [DW-1:0]       rd_data,
  output logic                rd_side
);

  // internal events, named for the checker
  logic          accept;
  logic          seq_hold;
  logic          seq_last;
  logic [AW-1:0] ea;
  logic [AW-1:0] wb_next;
  logic          wb_en;
  logic          misalign;
  logic [2:0]    cur_lo;
  logic [1:0]    cur_size;
  logic          cur_side;

  assign req_ready = !seq_hold;
  assign accept    = req_valid && req_ready;

  lsu_ea_calc #(
    .AW(AW), .OFS_LONG(OFS_LONG), .OFS_SHRT(OFS_SHRT), .CNW(CNW)
  ) u_ea (
    .base(req_base), .offset(req_offset), .use_long(req_long_ofs),
    .unaligned(req_unaligned), .neg(req_neg), .size(req_size), .mode(req_mode),
    .circ(req_circ), .circ_n(req_circ_n),
    .ea(ea), .wb_addr(wb_next), .wb_en(wb_en), .misalign(misalign)
  );

  lsu_beat_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept && !misalign), .ea(ea),
    .size(req_size), .store(req_store), .wdata(req_wdata), .side(req_side),
    .mem_valid(mem_valid), .mem_store(mem_store), .mem_beat(mem_beat),
    .mem_last(seq_last), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .cur_lo(cur_lo), .cur_size(cur_size),
    .cur_side(cur_side), .hold(seq_hold)
  );

  lsu_load_merge #(.DW(DW)) u_merge (
    .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_store(mem_store),
    .mem_beat(mem_beat), .mem_last(seq_last), .lo(cur_lo), .size(cur_size),
    .side(cur_side), .rdata(mem_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_side(rd_side)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid     <= 1'b0;
      wb_addr      <= '0;
      err_misalign <= 1'b0;
    end else begin
      wb_valid     <= accept && wb_en && !misalign;
      err_misalign <= accept && misalign;
      if (accept && wb_en && !misalign) wb_addr <= wb_next;
    end
  end

endmodule

// File: rtl/lsu_agen_chk.sv
module lsu_agen_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned NB = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          wb_valid,
  input logic          err_misalign,
  input logic          mem_valid,
  input logic          mem_store,
  input logic          mem_beat,
  input logic          mem_last,
  input logic [AW-1:0] mem_addr,
  input logic [NB-1:0] mem_be,
  input logic          rd_valid
);

  // R7
  split_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_last) |=> (mem_valid && mem_beat && mem_addr == $past(mem_addr) + AW'(NB)));

  // R6
  beat_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_be != '0 && mem_addr[2:0] == 3'b000));

  // R10
  stall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> (req_ready && mem_valid && mem_beat));

  // R5
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_misalign |-> (!mem_valid && !wb_valid));

  // R9
  rd_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(mem_valid && !mem_store && mem_last));

endmodule

bind lsu_agen lsu_agen_chk #(.AW(AW), .NB(DW/8)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .wb_valid(wb_valid),
  .err_misalign(err_misalign), .mem_valid(mem_valid), .mem_store(mem_store),
  .mem_beat(mem_beat), .mem_last(seq_last), .mem_addr(mem_addr),
  .mem_be(mem_be), .rd_valid(rd_valid)
);

// File: tb/lsu_agen_test.sv
module lsu_agen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_store = 1'b0;
  logic [1:0]  req_size = '0;
  logic [1:0]  req_mode = '0;
  logic        req_unaligned = 1'b0;
  logic        req_long_ofs = 1'b0;
  logic        req_neg = 1'b0;
  logic [14:0] req_offset = '0;
  logic [31:0] req_base = '0;
  logic        req_circ = 1'b0;
  logic [4:0]  req_circ_n = '0;
  logic [63:0] req_wdata = '0;
  logic        req_side = 1'b0;
  logic        wb_valid;
  logic [31:0] wb_addr;
  logic        err_misalign;
  logic        mem_valid, mem_store, mem_beat;
  logic [31:0] mem_addr;
  logic [7:0]  mem_be;
  logic [63:0] mem_wdata;
  logic [63:0] mem_rdata;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic        rd_side;

  int nvec = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lsu_agen uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_store(req_store), .req_size(req_size), .req_mode(req_mode),
    .req_unaligned(req_unaligned), .req_long_ofs(req_long_ofs), .req_neg(req_neg),
    .req_offset(req_offset), .req_base(req_base), .req_circ(req_circ),
    .req_circ_n(req_circ_n), .req_wdata(req_wdata), .req_side(req_side),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .err_misalign(err_misalign),
    .mem_valid(mem_valid), .mem_store(mem_store), .mem_beat(mem_beat),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rd_valid(rd_valid), .rd_data(rd_data), .rd_side(rd_side)
  );

  // memory contents are a function of the byte address
  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ {a[10:8], 5'b0} ^ 8'hA5;
  endfunction

  always_comb begin
    for (int k = 0; k < 8; k++) mem_rdata[8*k +: 8] = mem_byte(mem_addr + 32'(k));
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // checks the enabled lanes of the beat now on the port
  task automatic look_beat(input logic [31:0] ea, input int nb, input bit st,
                           input logic [63:0] wd, inout int lanes);
    logic [31:0] a;
    logic [31:0] idx;
    chk(mem_addr[2:0] == 3'b000, "R6 beat address alignment", 64'(mem_addr), 64'(mem_addr & ~32'h7));
    for (int k = 0; k < 8; k++) begin
      if (mem_be[k]) begin
        a = mem_addr + 32'(k);
        idx = a - ea;
        lanes++;
        chk(idx < 32'(nb), "R6 enabled lane address", 64'(a), 64'(ea));
        if (st && idx < 32'(nb))
          chk(mem_wdata[8*k +: 8] == wd[8*idx +: 8], "R8 store lane data",
              64'(mem_wdata[8*k +: 8]), 64'(wd[8*idx +: 8]));
      end
    end
  endtask

  task automatic run_vec(input int sz, input bit ua, input bit lng, input bit neg,
                         input int mode, input bit circ, input int cn,
                         input logic [31:0] base, input logic [14:0] ofs,
                         input bit st, input bit side);
    int nb;
    longint unsigned off, blk, wr64;
    logic [31:0] sum, wrapped, ea;
    bit eerr, ewb, esplit;
    int lanes;
    logic [63:0] wd, erd;
    nb  = 1 << sz;
    // R1: constant choice and scaling
    off = (lng && !ua) ? longint'(ofs) : longint'(ofs % 32);
    off = off * nb;
    // R2
    sum = neg ? (base - 32'(off)) : (base + 32'(off));
    // R4
    if (circ) begin
      blk  = 64'd1 << (cn + 1);
      wr64 = (longint'(base) - (longint'(base) % blk)) + (longint'(sum) % blk);
      wrapped = 32'(wr64);
    end else wrapped = sum;
    // R3
    ea  = (mode == 2) ? base : wrapped;
    ewb = (mode == 1 || mode == 2);
    eerr = !ua && (ea % nb) != 0;
    esplit = (ea % 8) + nb > 8;
    wd = 64'h0123_4567_89AB_CDEF ^ {base, ~base};
    for (int i = 0; i < 8; i++) erd[8*i +: 8] = (i < nb) ? mem_byte(ea + 32'(i)) : 8'h00;

    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_size = 2'(sz); req_mode = 2'(mode);
    req_unaligned = ua; req_long_ofs = lng; req_neg = neg; req_offset = ofs;
    req_base = base; req_circ = circ; req_circ_n = 5'(cn); req_wdata = wd; req_side = side;
    chk(req_ready == 1'b1, "R10 idle ready", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(err_misalign == eerr, "R5 misalign flag", 64'(err_misalign), 64'(eerr));
    chk(wb_valid == (ewb && !eerr), "R3 write-back valid", 64'(wb_valid), 64'(ewb && !eerr));
    if (ewb && !eerr) chk(wb_addr == wrapped, "R4 write-back value", 64'(wb_addr), 64'(wrapped));
    chk(mem_valid == !eerr, "R5 beat issued", 64'(mem_valid), 64'(!eerr));
    if (eerr) return;
    lanes = 0;
    chk(mem_beat == 1'b0 && mem_store == st, "R6 first beat", 64'({mem_beat, mem_store}), 64'({1'b0, st}));
    look_beat(ea, nb, st, wd, lanes);
    @(negedge clk);
    chk(mem_valid == esplit, "R7 second beat present", 64'(mem_valid), 64'(esplit));
    if (esplit) begin
      chk(mem_beat == 1'b1, "R7 second beat marker", 64'(mem_beat), 64'd1);
      look_beat(ea, nb, st, wd, lanes);
      @(negedge clk);
    end
    chk(lanes == nb, "R7 total enabled lanes", 64'(lanes), 64'(nb));
    if (!st) begin
      chk(rd_valid == 1'b1, "R9 load result valid", 64'(rd_valid), 64'd1);
      chk(rd_data == erd, "R9 load data", rd_data, erd);
      chk(rd_side == side, "R11 side tag", 64'(rd_side), 64'(side));
    end else begin
      chk(rd_valid == 1'b0, "R9 no result for store", 64'(rd_valid), 64'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({mem_valid, wb_valid, err_misalign, rd_valid, req_ready} == 5'b00001,
        "R10 reset state", 64'({mem_valid, wb_valid, err_misalign, rd_valid, req_ready}), 64'd1);

    // sweep: sizes, alignment mode, low base bits, update modes, wrap, sign/length, direction
    for (int sz = 0; sz < 4; sz++)
      for (int ua = 0; ua < 2; ua++)
        for (int lo = 0; lo < 8; lo++)
          for (int md = 0; md < 3; md++)
            for (int ci = 0; ci < 3; ci++)
              for (int k = 0; k < 4; k++)
                for (int st = 0; st < 2; st++)
                  run_vec(sz, ua[0], k[0], k[1], md, ci != 0, (ci == 1) ? 2 : 4,
                          {29'h1000_01FF, 3'(lo)}, lo[0] ? 15'h0005 : 15'h7FE3,
                          st[0], lo[1] ^ md[0]);

    // R3 reserved mode code, R4 widest circular block, R2 wrap below zero
    run_vec(3, 1'b1, 1'b1, 1'b0, 3, 1'b0, 0, 32'h0000_1005, 15'h0002, 1'b0, 1'b1);
    run_vec(2, 1'b0, 1'b1, 1'b0, 1, 1'b1, 31, 32'hFFFF_FFF8, 15'h0004, 1'b0, 1'b0);
    run_vec(1, 1'b1, 1'b0, 1'b1, 2, 1'b0, 0, 32'h0000_0003, 15'h001F, 1'b0, 1'b0);
    run_vec(0, 1'b0, 1'b1, 1'b0, 1, 1'b1, 0, 32'h0000_0041, 15'h7FFF, 1'b1, 1'b0);

    // R10: a request held behind a crossing load
    @(negedge clk);
    req_valid = 1'b1; req_store = 1'b0; req_size = 2'd3; req_mode = 2'd0;
    req_unaligned = 1'b1; req_long_ofs = 1'b0; req_neg = 1'b0; req_offset = 15'd0;
    req_base = 32'h0000_2006; req_circ = 1'b0; req_side = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b0, "R10 busy during first beat", 64'(req_ready), 64'd0);
    req_size = 2'd2; req_unaligned = 1'b0; req_base = 32'h0000_3010; req_side = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1 && mem_beat == 1'b1 && mem_addr == 32'h0000_2008,
        "R10 second beat then ready", 64'({req_ready, mem_beat, mem_addr}), 64'({1'b1, 1'b1, 32'h0000_2008}));
    @(negedge clk);
    req_valid = 1'b0;
    chk(rd_valid && rd_side && rd_data == {mem_byte(32'h200D), mem_byte(32'h200C), mem_byte(32'h200B),
        mem_byte(32'h200A), mem_byte(32'h2009), mem_byte(32'h2008), mem_byte(32'h2007), mem_byte(32'h2006)},
        "R9 merged result beside next beat", rd_data, 64'd0);
    chk(mem_valid && !mem_beat && mem_addr == 32'h0000_3010 && mem_be == 8'h0F,
        "R6 held request issued", 64'({mem_addr, mem_be}), 64'({32'h0000_3010, 8'h0F}));
    @(negedge clk);
    chk(mem_valid == 1'b0 && rd_valid == 1'b1, "R9 held load finishes", 64'({mem_valid, rd_valid}), 64'd1);

    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nfail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule